// File: doc/BRIEF.md
# GPIO and Port Event Interrupt Aggregator

This block collects interrupt causes from two general-purpose input pins and from per-port event strobes (remote wake, disconnect, device attach, over-voltage), holds each cause in a sticky status bit, masks the status with enable bits, and drives one interrupt pin. Each input pin is first brought into the clock domain through a two-flop synchronizer. It can then be watched either for edges or for levels. In edge mode, a low-to-high change sets the pin's "rise" status and a high-to-low change sets its "fall" status. In level mode, "rise" keeps setting while the pin is high and "fall" keeps setting while it is low.

Software reaches the block through a plain register port: a write strobe with address and data, and a combinational read data bus. Status bits clear when a one is written to them. The pin stage can drive the interrupt as an open-drain output, which is always active-low, or as a push-pull output with selectable polarity. A software override can force the asserted or deasserted state through the same output stage.

Top module: `gpio_irq_agg`

## Requirements
- R1: After synchronous reset, every readable register returns 0x00, no status bit is set, and the open-drain output is released (irq_oe=0, irq_pin=0).
- R2: The register at address g (g=0,1) returns the synchronized level of gpio_in[g] in bit 1. Bit 0 of the same register is the trigger mode, where 0 selects edge and 1 selects level.
- R3: In edge mode, a rising edge on gpio_in[g] sets status-A bit 4+2g+1 and a falling edge sets status-A bit 4+2g. Both appear within four clocks of the pin change.
- R4: In level mode, status-A bit 4+2g+1 is set on every clock while pin g is high, and bit 4+2g is set on every clock while it is low. A clearing write made while the condition holds therefore has no effect.
- R5: A one-cycle strobe on disc_evt[p] sets status-A bit 2p and one on wake_evt[p] sets status-A bit 2p+1. For status B (address 3), ovp_evt[p] sets bit p and attach_evt[p] sets bit 2+p. Status A is at address 2.
- R6: Writing a one to a status bit clears it, and writing zero leaves it unchanged. If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R7: The interrupt is active exactly when some status-A bit is set together with the same bit of enable A (address 4), or some status-B bit is set together with the same bit of enable B (address 5).
- R8: The output control register is at address 6, with bit0 push-pull, bit1 active-low, bit2 override enable and bit3 override value. When bit0 is 0 (open-drain), irq_pin is 0 and irq_oe equals the active state.
- R9: In push-pull mode, irq_oe is 1 and irq_pin equals the active state XOR bit1, so bit1=0 gives active-high and bit1=1 gives active-low.
- R10: When override is enabled, the active state equals the override value regardless of status and enables. It still passes through the configured output type and polarity.
- R11: Bits 7:4 of status B and enable B always read 0, and address 7 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| gpio_in | input | 2 | Asynchronous general-purpose pin inputs |
| wake_evt | input | 2 | Per-port remote wake strobes |
| disc_evt | input | 2 | Per-port disconnect strobes |
| attach_evt | input | 2 | Per-port device attach strobes |
| ovp_evt | input | 2 | Per-port over-voltage strobes |
| irq_pin | output | 1 | Interrupt pin drive value |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
Directed pin sequences raise and lower each input in edge mode, which shows that rise and fall land in separate bits and that a held level does not set them again. The same pins in level mode show that status keeps reasserting under a clearing write and stops once the level changes. Each output-type, polarity and override combination is applied against a known pending cause, which separates masking from pin encoding. A seeded random run of event strobes, clearing writes and enable changes, with set-versus-clear collisions, is compared against a bench model of the sticky bits and the masked interrupt.

// File: rtl/gia_pkg.sv
package gia_pkg;

    localparam int DATA_W       = 8;
    localparam int FIXED_REGS   = 5;   // status A/B, enable A/B, output control
    localparam int MODE_LVL_BIT = 0;
    localparam int MODE_PIN_BIT = 1;

    // Output control register layout (bits 3:0)
    typedef struct packed {
        logic ovr_val;
        logic ovr_en;
        logic active_low;
        logic push_pull;
    } out_ctrl_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } pin_evt_t;

    typedef struct packed {
        logic oe;
        logic lvl;
    } pad_drive_t;

    // Map a logical active state onto the pad
    function automatic pad_drive_t drive_pad(input logic active, input out_ctrl_t c);
        pad_drive_t d;
        if (c.push_pull) begin
            d.oe  = 1'b1;
            d.lvl = active ^ c.active_low;
        end else begin
            d.oe  = active;
            d.lvl = 1'b0;
        end
        return d;
    endfunction

endpackage

// File: rtl/gia_sync.sv
module gia_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gia_pin_detect.sv
module gia_pin_detect
    import gia_pkg::*;
#(
    parameter int NUM_PINS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_sync,
    input  logic [NUM_PINS-1:0] level_mode,
    output pin_evt_t            evt [NUM_PINS]
);
    logic [NUM_PINS-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= pin_sync;
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        always_comb begin
            if (level_mode[g]) begin
                evt[g].rise = pin_sync[g];
                evt[g].fall = ~pin_sync[g];
            end else begin
                evt[g].rise = pin_sync[g] & ~prev_q[g];
                evt[g].fall = ~pin_sync[g] & prev_q[g];
            end
        end
    end
endmodule

// File: rtl/gia_sticky_bank.sv
module gia_sticky_bank #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_in,
    input  logic [WIDTH-1:0] clr_in,
    output logic [WIDTH-1:0] stat
);
    logic [WIDTH-1:0] stat_q;

    // A hardware set in the same cycle overrides a clear
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr_in) | set_in;
    end

    assign stat = stat_q;
endmodule

// File: rtl/gia_irq_out.sv
module gia_irq_out
    import gia_pkg::*;
#(
    parameter int A_W = 8,
    parameter int B_W = 4
) (
    input  logic [A_W-1:0] stat_a,
    input  logic [A_W-1:0] en_a,
    input  logic [B_W-1:0] stat_b,
    input  logic [B_W-1:0] en_b,
    input  out_ctrl_t      ctrl,
    output logic           irq_req,
    output logic           irq_pin,
    output logic           irq_oe
);
    logic       active;
    pad_drive_t pad;

    always_comb begin
        irq_req = (|(stat_a & en_a)) | (|(stat_b & en_b));
        active  = ctrl.ovr_en ? ctrl.ovr_val : irq_req;
        pad     = drive_pad(active, ctrl);
        irq_pin = pad.lvl;
        irq_oe  = pad.oe;
    end
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
    import gia_pkg::*;
#(
    parameter int NUM_GPIO    = 2,
    parameter int NUM_PORTS   = 2,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = $clog2(NUM_GPIO + FIXED_REGS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_GPIO-1:0]  gpio_in,
    input  logic [NUM_PORTS-1:0] wake_evt,
    input  logic [NUM_PORTS-1:0] disc_evt,
    input  logic [NUM_PORTS-1:0] attach_evt,
    input  logic [NUM_PORTS-1:0] ovp_evt,
    output logic                 irq_pin,
    output logic                 irq_oe
);
    localparam int STAT_A_W = 2 * NUM_GPIO + 2 * NUM_PORTS;
    localparam int STAT_B_W = 2 * NUM_PORTS;
    localparam int CTRL_W   = $bits(out_ctrl_t);
    localparam logic [ADDR_W-1:0] STAT_A_ADDR = ADDR_W'(NUM_GPIO);
    localparam logic [ADDR_W-1:0] STAT_B_ADDR = ADDR_W'(NUM_GPIO + 1);
    localparam logic [ADDR_W-1:0] EN_A_ADDR   = ADDR_W'(NUM_GPIO + 2);
    localparam logic [ADDR_W-1:0] EN_B_ADDR   = ADDR_W'(NUM_GPIO + 3);
    localparam logic [ADDR_W-1:0] CTRL_ADDR   = ADDR_W'(NUM_GPIO + 4);

    // ---------------- configuration registers ----------------
    logic [NUM_GPIO-1:0] lvl_mode_q;
    logic [STAT_A_W-1:0] en_a_q;
    logic [STAT_B_W-1:0] en_b_q;
    out_ctrl_t           ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_mode_q <= '0;
            en_a_q     <= '0;
            en_b_q     <= '0;
            ctrl_q     <= '0;
        end else if (reg_we) begin
            for (int g = 0; g < NUM_GPIO; g++) begin
                if (reg_addr == ADDR_W'(g)) lvl_mode_q[g] <= reg_wdata[MODE_LVL_BIT];
            end
            if (reg_addr == EN_A_ADDR) en_a_q <= reg_wdata[STAT_A_W-1:0];
            if (reg_addr == EN_B_ADDR) en_b_q <= reg_wdata[STAT_B_W-1:0];
            if (reg_addr == CTRL_ADDR) ctrl_q <= out_ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
    end

    // ---------------- pin path ----------------
    logic [NUM_GPIO-1:0] pin_sync;
    pin_evt_t            pin_evt [NUM_GPIO];

    gia_sync #(.WIDTH(NUM_GPIO), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (gpio_in),
        .sync_out (pin_sync)
    );

    gia_pin_detect #(.NUM_PINS(NUM_GPIO)) u_detect (
        .clk        (clk),
        .rst        (rst),
        .pin_sync   (pin_sync),
        .level_mode (lvl_mode_q),
        .evt        (pin_evt)
    );

    // ---------------- status set/clear vectors ----------------
    logic [STAT_A_W-1:0] set_a, clr_a, stat_a;
    logic [STAT_B_W-1:0] set_b, clr_b, stat_b;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign set_a[2*p]           = disc_evt[p];
        assign set_a[2*p+1]         = wake_evt[p];
        assign set_b[p]             = ovp_evt[p];
        assign set_b[NUM_PORTS + p] = attach_evt[p];
    end

    for (genvar g = 0; g < NUM_GPIO; g++) begin : g_gpio
        assign set_a[2*NUM_PORTS + 2*g]     = pin_evt[g].fall;
        assign set_a[2*NUM_PORTS + 2*g + 1] = pin_evt[g].rise;
    end

    assign clr_a = (reg_we && reg_addr == STAT_A_ADDR) ? reg_wdata[STAT_A_W-1:0] : '0;
    assign clr_b = (reg_we && reg_addr == STAT_B_ADDR) ? reg_wdata[STAT_B_W-1:0] : '0;

    gia_sticky_bank #(.WIDTH(STAT_A_W)) u_bank_a (
        .clk    (clk),
        .rst    (rst),
        .set_in (set_a),
        .clr_in (clr_a),
        .stat   (stat_a)
    );

    gia_sticky_bank #(.WIDTH(STAT_B_W)) u_bank_b (
        .clk    (clk),
        .rst    (rst),
        .set_in (set_b),
        .clr_in (clr_b),
        .stat   (stat_b)
    );

    // ---------------- interrupt output ----------------
    logic irq_req;

    gia_irq_out #(.A_W(STAT_A_W), .B_W(STAT_B_W)) u_out (
        .stat_a  (stat_a),
        .en_a    (en_a_q),
        .stat_b  (stat_b),
        .en_b    (en_b_q),
        .ctrl    (ctrl_q),
        .irq_req (irq_req),
        .irq_pin (irq_pin),
        .irq_oe  (irq_oe)
    );

    // ---------------- read back ----------------
    always_comb begin
        reg_rdata = '0;
        for (int g = 0; g < NUM_GPIO; g++) begin
            if (reg_addr == ADDR_W'(g)) begin
                reg_rdata[MODE_LVL_BIT] = lvl_mode_q[g];
                reg_rdata[MODE_PIN_BIT] = pin_sync[g];
            end
        end
        if (reg_addr == STAT_A_ADDR) reg_rdata = DATA_W'(stat_a);
        if (reg_addr == STAT_B_ADDR) reg_rdata = DATA_W'(stat_b);
        if (reg_addr == EN_A_ADDR)   reg_rdata = DATA_W'(en_a_q);
        if (reg_addr == EN_B_ADDR)   reg_rdata = DATA_W'(en_b_q);
        if (reg_addr == CTRL_ADDR)   reg_rdata = DATA_W'(ctrl_q);
    end
endmodule

// File: rtl/gia_checker.sv
module gia_checker #(
    parameter int A_W    = 8,
    parameter int B_W    = 4,
    parameter int ADDR_W = 3,
    parameter logic [ADDR_W-1:0] STAT_A_ADDR = 3'd2,
    parameter logic [ADDR_W-1:0] STAT_B_ADDR = 3'd3
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic [A_W-1:0]    set_a,
    input logic [A_W-1:0]    stat_a,
    input logic [B_W-1:0]    set_b,
    input logic [B_W-1:0]    stat_b,
    input logic              push_pull,
    input logic              active_low,
    input logic              ovr_en,
    input logic              ovr_val,
    input logic              irq_req,
    input logic              irq_pin,
    input logic              irq_oe
);
    logic [A_W-1:0] clr_a;
    logic [B_W-1:0] clr_b;
    assign clr_a = (reg_we && reg_addr == STAT_A_ADDR) ? reg_wdata[A_W-1:0] : '0;
    assign clr_b = (reg_we && reg_addr == STAT_B_ADDR) ? reg_wdata[B_W-1:0] : '0;

    p_set_lands_r5: assert property (@(posedge clk) disable iff (rst)
        (|set_a) |=> (($past(set_a) & ~stat_a) == '0));

    p_set_lands_b_r5: assert property (@(posedge clk) disable iff (rst)
        (|set_b) |=> (($past(set_b) & ~stat_b) == '0));

    p_w1c_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (|(clr_a & ~set_a)) |=> (($past(clr_a & ~set_a) & stat_a) == '0));

    p_sticky_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (|(stat_a & ~clr_a)) |=> (($past(stat_a & ~clr_a) & ~stat_a) == '0));

    p_open_drain_low_r8: assert property (@(posedge clk) disable iff (rst)
        !push_pull |-> !irq_pin);

    p_pp_always_driven_r9: assert property (@(posedge clk) disable iff (rst)
        push_pull |-> irq_oe);

    p_pp_polarity_r9: assert property (@(posedge clk) disable iff (rst)
        (push_pull && !ovr_en) |-> (irq_pin == (irq_req ^ active_low)));

    p_override_r10: assert property (@(posedge clk) disable iff (rst)
        (push_pull && ovr_en) |-> (irq_pin == (ovr_val ^ active_low)));

    p_reserved_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == STAT_B_ADDR) |-> (reg_rdata[7:4] == 4'h0));
endmodule

bind gpio_irq_agg gia_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .set_a      (set_a),
    .stat_a     (stat_a),
    .set_b      (set_b),
    .stat_b     (stat_b),
    .push_pull  (ctrl_q.push_pull),
    .active_low (ctrl_q.active_low),
    .ovr_en     (ctrl_q.ovr_en),
    .ovr_val    (ctrl_q.ovr_val),
    .irq_req    (irq_req),
    .irq_pin    (irq_pin),
    .irq_oe     (irq_oe)
);

// File: tb/tb_gpio_irq_agg.sv
module tb_gpio_irq_agg;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;
    localparam int N_RANDOM   = 300;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_we;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [1:0] gpio_in, wake_evt, disc_evt, attach_evt, ovp_evt;
    logic       irq_pin, irq_oe;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_agg dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpio_in(gpio_in),
        .wake_evt(wake_evt), .disc_evt(disc_evt), .attach_evt(attach_evt),
        .ovp_evt(ovp_evt), .irq_pin(irq_pin), .irq_oe(irq_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic pin_chk(input string tag, input logic exp_oe, input logic exp_pin);
        #1;
        chk(tag, {6'd0, irq_oe, irq_pin}, {6'd0, exp_oe, exp_pin});
    endtask

    task automatic pulse(input logic [1:0] w, input logic [1:0] d,
                         input logic [1:0] at, input logic [1:0] o);
        @(negedge clk);
        wake_evt = w; disc_evt = d; attach_evt = at; ovp_evt = o;
        @(negedge clk);
        wake_evt = '0; disc_evt = '0; attach_evt = '0; ovp_evt = '0;
    endtask

    function automatic logic [7:0] pack_a(input logic [1:0] w, input logic [1:0] d);
        return {4'h0, w[1], d[1], w[0], d[0]};
    endfunction

    function automatic logic [3:0] pack_b(input logic [1:0] at, input logic [1:0] o);
        return {at[1], at[0], o[1], o[0]};
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] exp_a, en_a;
        logic [3:0] exp_b, en_b;
        void'($urandom(32'd20240611));
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        gpio_in = '0; wake_evt = '0; disc_evt = '0; attach_evt = '0; ovp_evt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 8; a++) rd_chk("R1 reset reg", 3'(a), 8'h00);
        pin_chk("R1 reset pin released", 1'b0, 1'b0);

        // R2 / R3 edge mode on gpio0
        @(negedge clk); gpio_in[0] = 1'b1;
        repeat (4) @(negedge clk);
        rd_chk("R2 level bit gpio0 high", 3'd0, 8'h02);
        rd_chk("R3 rise gpio0", 3'd2, 8'h20);
        wr(3'd2, 8'h20);
        rd_chk("R6 w1c rise gpio0", 3'd2, 8'h00);
        repeat (3) @(negedge clk);
        rd_chk("R3 held level no re-set", 3'd2, 8'h00);
        gpio_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        rd_chk("R3 fall gpio0", 3'd2, 8'h10);
        rd_chk("R2 level bit gpio0 low", 3'd0, 8'h00);
        gpio_in[1] = 1'b1;
        repeat (4) @(negedge clk);
        rd_chk("R3 rise gpio1", 3'd2, 8'h90);
        wr(3'd2, 8'h00);
        rd_chk("R6 zero write keeps", 3'd2, 8'h90);
        wr(3'd2, 8'hFF);
        rd_chk("R6 clear all", 3'd2, 8'h00);

        // R4 level mode on gpio1 (pin high)
        wr(3'd1, 8'h01);
        @(negedge clk);
        rd_chk("R2 mode readback", 3'd1, 8'h03);
        rd_chk("R4 level high sets rise", 3'd2, 8'h80);
        wr(3'd2, 8'h80);
        rd_chk("R4 clear ignored while high", 3'd2, 8'h80);
        gpio_in[1] = 1'b0;
        repeat (4) @(negedge clk);
        rd_chk("R4 level low sets fall", 3'd2, 8'hC0);
        wr(3'd2, 8'h80);
        rd_chk("R4 rise clears after level drop", 3'd2, 8'h40);
        wr(3'd2, 8'h40);
        rd_chk("R4 fall reasserts while low", 3'd2, 8'h40);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'hFF);
        rd_chk("R4 back to edge mode clears", 3'd2, 8'h00);

        // R5 / R7 / R8 / R9 / R10 output stage
        pulse(2'b00, 2'b00, 2'b00, 2'b10);
        rd_chk("R5 ovp port1", 3'd3, 8'h02);
        pin_chk("R7 no enable no irq", 1'b0, 1'b0);
        wr(3'd5, 8'h02);
        pin_chk("R8 open drain asserted", 1'b1, 1'b0);
        wr(3'd5, 8'h01);
        pin_chk("R7 wrong enable bit", 1'b0, 1'b0);
        wr(3'd6, 8'h01);
        pin_chk("R9 pp high idle", 1'b1, 1'b0);
        wr(3'd5, 8'h02);
        pin_chk("R9 pp high asserted", 1'b1, 1'b1);
        wr(3'd6, 8'h03);
        pin_chk("R9 pp low asserted", 1'b1, 1'b0);
        wr(3'd6, 8'h07);
        pin_chk("R10 override off active-low", 1'b1, 1'b1);
        wr(3'd6, 8'h05);
        pin_chk("R10 override off masks pending", 1'b1, 1'b0);
        wr(3'd5, 8'h00);
        wr(3'd6, 8'h0D);
        pin_chk("R10 override on pp high", 1'b1, 1'b1);
        wr(3'd6, 8'h0C);
        pin_chk("R10 override on open drain", 1'b1, 1'b0);
        wr(3'd6, 8'h00);
        pin_chk("R8 open drain released", 1'b0, 1'b0);

        // R6 set wins over clear in the same cycle
        @(negedge clk);
        disc_evt = 2'b01; reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h01;
        @(negedge clk);
        disc_evt = 2'b00; reg_we = 1'b0;
        rd_chk("R6 set wins", 3'd2, 8'h01);

        // R5 / R11 remaining events and reserved bits
        pulse(2'b10, 2'b00, 2'b11, 2'b01);
        rd_chk("R5 wake port1 status A", 3'd2, 8'h09);
        rd_chk("R11 status B upper zero", 3'd3, 8'h0F);
        wr(3'd5, 8'hFF);
        rd_chk("R11 enable B upper zero", 3'd5, 8'h0F);
        rd_chk("R11 unmapped address", 3'd7, 8'h00);

        // cleanup
        wr(3'd5, 8'h00);
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'hFF);
        rd_chk("R6 cleanup A", 3'd2, 8'h00);
        rd_chk("R6 cleanup B", 3'd3, 8'h00);

        // Random phase (R5 R6 R7): strobes, clears, enables in open-drain mode
        exp_a = '0; exp_b = '0; en_a = '0; en_b = '0;
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [1:0] w, d, at, o;
            logic [7:0] wd;
            logic [2:0] sel;
            logic [7:0] ca;
            logic [3:0] cb;
            w  = 2'($urandom) & 2'($urandom);
            d  = 2'($urandom) & 2'($urandom);
            at = 2'($urandom) & 2'($urandom);
            o  = 2'($urandom) & 2'($urandom);
            wd = 8'($urandom);
            sel = 3'($urandom_range(0, 5));
            @(negedge clk);
            wake_evt = w; disc_evt = d; attach_evt = at; ovp_evt = o;
            reg_we = (sel >= 3'd2); reg_addr = sel; reg_wdata = wd;
            @(negedge clk);
            wake_evt = '0; disc_evt = '0; attach_evt = '0; ovp_evt = '0; reg_we = 1'b0;
            ca = (sel == 3'd2) ? (wd & 8'h0F) : 8'h00;
            cb = (sel == 3'd3) ? wd[3:0] : 4'h0;
            exp_a = (exp_a & ~ca) | pack_a(w, d);
            exp_b = (exp_b & ~cb) | pack_b(at, o);
            if (sel == 3'd4) en_a = wd;
            if (sel == 3'd5) en_b = wd[3:0];
            rd_chk("R5 R6 random status A", 3'd2, exp_a);
            rd_chk("R5 R6 random status B", 3'd3, {4'h0, exp_b});
            pin_chk("R7 random irq", (|(exp_a & en_a)) | (|(exp_b & en_b)), 1'b0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule